// File: doc/BRIEF.md
# Frequency-Change Watchdog Recovery Controller

This controller keeps watch over a clock frequency change that software asks for. Each accepted request updates the active frequency selection at once. If a timeout is programmed, the request also starts a seconds countdown. Software confirms that the system survived the new clock by writing zero to the timeout field. If that confirmation does not arrive before the countdown ends, the controller asserts a system reset on an open-drain pin and raises an alarm flag. It then starts counting again.

Escalation has two stages. The first expiry only resets the system and leaves the frequency alone. Every later expiry also resets, and in addition it falls back to a safe frequency. A policy bit selects which one: the hardware-strap value latched after reset, or the software setting that was in force before the last request. The reset pin is shared with a power-down input, and a role bit decides which of the two it is. A separate fine-frequency port captures a divider pair (N, R) only on a rising edge of its enable bit.

Top module: `fcw_recovery_ctrl`

## Requirements
- R1: In the first clock after reset is released, `fsel_active` takes the value of `strap_fsel`. `wd_alarm` and `rst_od_low` are 0.
- R2: A one-cycle `sw_fsel_wr` loads `sw_fsel` into `fsel_active` at the next edge. When `tmo_sel` is nonzero, the same write also starts the countdown.
- R3: A write made while `tmo_sel` is 0 changes the frequency but arms nothing. No number of ticks then raises the alarm or drives the reset.
- R4: Once armed, expiry comes on the `tmo_sel`-th `sec_tick` after the arming write, not one tick earlier. A new write restarts the count from the beginning.
- R5: The first expiry sets `wd_alarm`, fires a reset pulse and leaves `fsel_active` unchanged. The countdown then reloads.
- R6: The second expiry after arming fires a reset pulse. With `revert_sel` = 0 it also returns `fsel_active` to the latched strap value.
- R7: With `revert_sel` = 1, a second or later expiry returns `fsel_active` to the software setting written before the most recent write.
- R8: Setting `tmo_sel` to 0 clears `wd_alarm` at the next edge, stops the countdown and keeps the current frequency. Giving `tmo_sel` a nonzero value again without a new write arms nothing.
- R9: With `pin_role_pd` = 1, `rst_od_low` stays 0 even across an expiry, and `pwrdn_req` follows the inverse of `pd_pin_n`. With `pin_role_pd` = 0, `pwrdn_req` is 0.
- R10: `fine_n_q` and `fine_r_q` capture `fine_n` and `fine_r` only at an edge where `fine_en` has gone from 0 to 1. Holding `fine_en` at 1, or at 0, leaves them unchanged.
- R11: Every expiry after the second repeats the same action: reset pulse, revert and alarm. This continues until `tmo_sel` is cleared.
- R12: Each reset pulse keeps `rst_od_low` at 1 for exactly `PULSE_CLKS` clocks. The pulse starts in the cycle after the expiring tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fsel | input | FSEL_W | Hardware-strap frequency selection, sampled once after reset |
| sw_fsel | input | FSEL_W | Frequency selection requested by software |
| sw_fsel_wr | input | 1 | One-cycle strobe that applies `sw_fsel` |
| tmo_sel | input | 4 | Timeout in seconds; 0 disables and clears |
| revert_sel | input | 1 | Fallback choice: 0 strap value, 1 setting before last |
| pin_role_pd | input | 1 | Shared pin role: 1 power-down input, 0 reset output |
| pd_pin_n | input | 1 | Level sensed on the shared pin |
| sec_tick | input | 1 | One-cycle pulse once per second |
| fine_n | input | FINE_N_W | Fine-frequency N value |
| fine_r | input | FINE_R_W | Fine-frequency R value |
| fine_en | input | 1 | Fine-frequency enable; a rising edge captures N and R |
| fsel_active | output | FSEL_W | Frequency selection in force |
| wd_alarm | output | 1 | Watchdog alarm flag |
| rst_od_low | output | 1 | Open-drain pull-down enable for the reset pin |
| pwrdn_req | output | 1 | Power-down request taken from the shared pin |
| fine_n_q | output | FINE_N_W | Captured N value |
| fine_r_q | output | FINE_R_W | Captured R value |

## Verification
Each result has a fixed delay after its stimulus:
- Writes, clears and fine-enable edges show up one edge after the stimulus.
- Alarm and revert appear at the same edge that takes in the expiring tick.
- The reset pulse covers the `PULSE_CLKS` cycles that follow that edge.

The bench drives every input at a falling edge and reads the outputs at the next falling edge, half a cycle after the register that produces them. Each tick is followed by a quiet gap longer than the pulse. A falling-edge monitor counts the cycles in which the reset is driven, so every tick is scored both by the state after it and by the exact pulse length it caused.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

  // Width of the seconds timeout field
  localparam int unsigned TMO_W = 4;

  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,  // no countdown running
    WD_WAIT1 = 2'd1,  // armed, no expiry yet
    WD_WAITN = 2'd2   // armed, at least one expiry seen
  } wd_stage_e;

  function automatic logic tmo_active(input logic [TMO_W-1:0] sel);
    return sel != '0;
  endfunction

  function automatic logic last_second(input logic [TMO_W-1:0] remain);
    return remain == TMO_W'(1);
  endfunction

  function automatic logic [TMO_W-1:0] count_next(input logic [TMO_W-1:0] remain,
                                                  input logic [TMO_W-1:0] reload);
    return last_second(remain) ? reload : remain - TMO_W'(1);
  endfunction

endpackage

// File: rtl/fcw_wd_timer.sv
module fcw_wd_timer
  import fcw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [TMO_W-1:0] tmo_sel,
  input  logic             tick,
  output logic             armed,
  output logic             expire,
  output logic             revert,
  output logic             alarm
);

  logic [TMO_W-1:0] remain;
  wd_stage_e        stage;
  logic             tmo_on;

  assign tmo_on = tmo_active(tmo_sel);
  assign armed  = (stage != WD_OFF);
  // A write in the same cycle restarts the count and hides the tick
  assign expire = armed & tmo_on & ~arm & tick & last_second(remain);
  assign revert = expire & (stage == WD_WAITN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage  <= WD_OFF;
      remain <= '0;
      alarm  <= 1'b0;
    end else if (!tmo_on) begin
      stage  <= WD_OFF;
      remain <= '0;
      alarm  <= 1'b0;
    end else if (arm) begin
      stage  <= WD_WAIT1;
      remain <= tmo_sel;
    end else if (armed && tick) begin
      remain <= count_next(remain, tmo_sel);
      if (expire) begin
        stage <= WD_WAITN;
        alarm <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fcw_freq_hist.sv
module fcw_freq_hist #(
  parameter int unsigned FSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FSEL_W-1:0] strap,
  input  logic              wr,
  input  logic [FSEL_W-1:0] wr_val,
  input  logic              revert,
  input  logic              revert_sel,
  output logic [FSEL_W-1:0] active,
  output logic              ready
);

  logic [FSEL_W-1:0] strap_q;
  logic [FSEL_W-1:0] cur_sw;
  logic [FSEL_W-1:0] prev_sw;

  function automatic logic [FSEL_W-1:0] pick_revert(input logic              use_prev,
                                                    input logic [FSEL_W-1:0] hw,
                                                    input logic [FSEL_W-1:0] before_last);
    return use_prev ? before_last : hw;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready   <= 1'b0;
      strap_q <= '0;
      cur_sw  <= '0;
      prev_sw <= '0;
      active  <= '0;
    end else if (!ready) begin
      ready   <= 1'b1;
      strap_q <= strap;
      cur_sw  <= strap;
      prev_sw <= strap;
      active  <= strap;
    end else if (wr) begin
      prev_sw <= cur_sw;
      cur_sw  <= wr_val;
      active  <= wr_val;
    end else if (revert) begin
      active <= pick_revert(revert_sel, strap_q, prev_sw);
    end
  end

endmodule

// File: rtl/fcw_rst_pulse.sv
module fcw_rst_pulse #(
  parameter int unsigned PULSE_CLKS = 600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic role_pd,
  input  logic pd_pin_n,
  output logic od_low,
  output logic pwrdn_req
);

  localparam int unsigned CW = $clog2(PULSE_CLKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (fire)       cnt <= CW'(PULSE_CLKS);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign od_low    = (cnt != '0) & ~role_pd;
  assign pwrdn_req = role_pd & ~pd_pin_n;

endmodule

// File: rtl/fcw_fine_latch.sv
module fcw_fine_latch #(
  parameter int unsigned NW = 7,
  parameter int unsigned RW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NW-1:0] n_in,
  input  logic [RW-1:0] r_in,
  output logic [NW-1:0] n_q,
  output logic [RW-1:0] r_q,
  output logic          rise
);

  logic en_d;

  assign rise = en & ~en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d <= 1'b0;
      n_q  <= '0;
      r_q  <= '0;
    end else begin
      en_d <= en;
      if (rise) begin
        n_q <= n_in;
        r_q <= r_in;
      end
    end
  end

endmodule

// File: rtl/fcw_recovery_ctrl.sv
module fcw_recovery_ctrl
  import fcw_pkg::*;
#(
  parameter int unsigned FSEL_W     = 4,
  parameter int unsigned FINE_N_W   = 7,
  parameter int unsigned FINE_R_W   = 6,
  parameter int unsigned PULSE_CLKS = 600000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FSEL_W-1:0]   strap_fsel,
  input  logic [FSEL_W-1:0]   sw_fsel,
  input  logic                sw_fsel_wr,
  input  logic [TMO_W-1:0]    tmo_sel,
  input  logic                revert_sel,
  input  logic                pin_role_pd,
  input  logic                pd_pin_n,
  input  logic                sec_tick,
  input  logic [FINE_N_W-1:0] fine_n,
  input  logic [FINE_R_W-1:0] fine_r,
  input  logic                fine_en,
  output logic [FSEL_W-1:0]   fsel_active,
  output logic                wd_alarm,
  output logic                rst_od_low,
  output logic                pwrdn_req,
  output logic [FINE_N_W-1:0] fine_n_q,
  output logic [FINE_R_W-1:0] fine_r_q
);

  // Named internal events, brought out for the checker
  logic hist_ready;
  logic wr_ok;
  logic wd_arm;
  logic wd_armed;
  logic wd_expire;
  logic wd_revert;
  logic fine_rise;

  assign wr_ok  = sw_fsel_wr & hist_ready;
  assign wd_arm = wr_ok & tmo_active(tmo_sel);

  fcw_wd_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (wd_arm),
    .tmo_sel (tmo_sel),
    .tick    (sec_tick),
    .armed   (wd_armed),
    .expire  (wd_expire),
    .revert  (wd_revert),
    .alarm   (wd_alarm)
  );

  fcw_freq_hist #(.FSEL_W(FSEL_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap      (strap_fsel),
    .wr         (wr_ok),
    .wr_val     (sw_fsel),
    .revert     (wd_revert),
    .revert_sel (revert_sel),
    .active     (fsel_active),
    .ready      (hist_ready)
  );

  fcw_rst_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (wd_expire),
    .role_pd   (pin_role_pd),
    .pd_pin_n  (pd_pin_n),
    .od_low    (rst_od_low),
    .pwrdn_req (pwrdn_req)
  );

  fcw_fine_latch #(.NW(FINE_N_W), .RW(FINE_R_W)) u_fine (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (fine_en),
    .n_in  (fine_n),
    .r_in  (fine_r),
    .n_q   (fine_n_q),
    .r_q   (fine_r_q),
    .rise  (fine_rise)
  );

endmodule

// File: rtl/fcw_recovery_ctrl_chk.sv
module fcw_recovery_ctrl_chk #(
  parameter int unsigned FSEL_W   = 4,
  parameter int unsigned FINE_N_W = 7,
  parameter int unsigned FINE_R_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sec_tick,
  input logic                sw_fsel_wr,
  input logic [3:0]          tmo_sel,
  input logic                pin_role_pd,
  input logic [FSEL_W-1:0]   fsel_active,
  input logic                wd_alarm,
  input logic                rst_od_low,
  input logic [FINE_N_W-1:0] fine_n_q,
  input logic [FINE_R_W-1:0] fine_r_q,
  input logic                wd_expire,
  input logic                wd_revert,
  input logic                fine_rise,
  input logic                hist_ready
);

  a_r4_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |-> sec_tick);

  a_r5_alarm_from_expire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_alarm) |-> $past(wd_expire));

  a_r12_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_expire && !pin_role_pd) |=> rst_od_low);

  a_r9_quiet_in_pd_role: assert property (@(posedge clk) disable iff (!rst_n)
    pin_role_pd |-> !rst_od_low);

  a_r8_clear_drops_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_sel == 4'd0) |=> !wd_alarm);

  a_r6_freq_moves_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ready && !sw_fsel_wr && !wd_revert) |=> $stable(fsel_active));

  a_r10_fine_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_rise |=> ($stable(fine_n_q) && $stable(fine_r_q)));

endmodule

bind fcw_recovery_ctrl fcw_recovery_ctrl_chk #(
  .FSEL_W   (FSEL_W),
  .FINE_N_W (FINE_N_W),
  .FINE_R_W (FINE_R_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick    (sec_tick),
  .sw_fsel_wr  (sw_fsel_wr),
  .tmo_sel     (tmo_sel),
  .pin_role_pd (pin_role_pd),
  .fsel_active (fsel_active),
  .wd_alarm    (wd_alarm),
  .rst_od_low  (rst_od_low),
  .fine_n_q    (fine_n_q),
  .fine_r_q    (fine_r_q),
  .wd_expire   (wd_expire),
  .wd_revert   (wd_revert),
  .fine_rise   (fine_rise),
  .hist_ready  (hist_ready)
);

// File: tb/fcw_recovery_ctrl_tb.sv
`timescale 1ns/1ps
module fcw_recovery_ctrl_tb;

  localparam int PULSE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] strap_fsel = 4'hA;
  logic [3:0] sw_fsel = 4'h0;
  logic       sw_fsel_wr = 1'b0;
  logic [3:0] tmo_sel = 4'h0;
  logic       revert_sel = 1'b0;
  logic       pin_role_pd = 1'b0;
  logic       pd_pin_n = 1'b1;
  logic       sec_tick = 1'b0;
  logic [6:0] fine_n = '0;
  logic [5:0] fine_r = '0;
  logic       fine_en = 1'b0;
  logic [3:0] fsel_active;
  logic       wd_alarm, rst_od_low, pwrdn_req;
  logic [6:0] fine_n_q;
  logic [5:0] fine_r_q;

  int vectors = 0;
  int errors = 0;
  int od_cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fcw_recovery_ctrl #(.PULSE_CLKS(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_fsel(strap_fsel), .sw_fsel(sw_fsel),
    .sw_fsel_wr(sw_fsel_wr), .tmo_sel(tmo_sel), .revert_sel(revert_sel),
    .pin_role_pd(pin_role_pd), .pd_pin_n(pd_pin_n), .sec_tick(sec_tick),
    .fine_n(fine_n), .fine_r(fine_r), .fine_en(fine_en),
    .fsel_active(fsel_active), .wd_alarm(wd_alarm), .rst_od_low(rst_od_low),
    .pwrdn_req(pwrdn_req), .fine_n_q(fine_n_q), .fine_r_q(fine_r_q)
  );

  always @(negedge clk) if (rst_od_low) od_cycles++;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic write_freq(input logic [3:0] v);
    sw_fsel = v; sw_fsel_wr = 1'b1;
    @(negedge clk);
    sw_fsel_wr = 1'b0;
  endtask

  // One tick, then a gap longer than the reset pulse
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      repeat (PULSE + 3) @(negedge clk);
    end
  endtask

  task automatic clear_tmo();
    tmo_sel = 4'h0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strap latched", fsel_active, 4'hA);
    chk("R1 alarm clear", wd_alarm, 0);
    chk("R1 reset idle", rst_od_low, 0);
  endtask

  task automatic t_unprotected();
    int od0;
    tmo_sel = 4'h0;
    write_freq(4'h5);
    chk("R3 freq changed", fsel_active, 4'h5);
    od0 = od_cycles;
    ticks(20);
    chk("R3 no alarm", wd_alarm, 0);
    chk("R3 no pulse", od_cycles - od0, 0);
  endtask

  task automatic t_escalate_strap();
    int od0;
    tmo_sel = 4'h3; revert_sel = 1'b0;
    write_freq(4'h6);
    chk("R2 new freq", fsel_active, 4'h6);
    od0 = od_cycles;
    ticks(2);
    chk("R4 not early", wd_alarm, 0);
    chk("R4 no pulse early", od_cycles - od0, 0);
    ticks(1);
    chk("R5 alarm set", wd_alarm, 1);
    chk("R12 pulse width", od_cycles - od0, PULSE);
    chk("R5 freq kept", fsel_active, 4'h6);
    od0 = od_cycles;
    ticks(2);
    chk("R6 reload wait", od_cycles - od0, 0);
    ticks(1);
    chk("R6 strap revert", fsel_active, 4'hA);
    chk("R6 pulse", od_cycles - od0, PULSE);
    od0 = od_cycles;
    ticks(3);
    chk("R11 repeat pulse", od_cycles - od0, PULSE);
    chk("R11 still reverted", fsel_active, 4'hA);
    chk("R11 alarm", wd_alarm, 1);
  endtask

  task automatic t_clear();
    int od0;
    clear_tmo();
    chk("R8 alarm cleared", wd_alarm, 0);
    tmo_sel = 4'h2;
    od0 = od_cycles;
    ticks(6);
    chk("R8 timer stopped", od_cycles - od0, 0);
    chk("R8 no alarm", wd_alarm, 0);
    chk("R8 freq kept", fsel_active, 4'hA);
    clear_tmo();
  endtask

  task automatic t_escalate_prev();
    tmo_sel = 4'h2; revert_sel = 1'b1;
    write_freq(4'h7);
    ticks(2);
    chk("R7 first expiry keeps", fsel_active, 4'h7);
    ticks(2);
    chk("R7 revert before last", fsel_active, 4'h6);
    clear_tmo();
  endtask

  task automatic t_pin_role();
    int od0;
    pin_role_pd = 1'b1; pd_pin_n = 1'b0;
    @(negedge clk);
    chk("R9 powerdown follows", pwrdn_req, 1);
    tmo_sel = 4'h1;
    write_freq(4'h3);
    od0 = od_cycles;
    ticks(1);
    chk("R9 alarm still set", wd_alarm, 1);
    chk("R9 pin not driven", od_cycles - od0, 0);
    pd_pin_n = 1'b1;
    @(negedge clk);
    chk("R9 powerdown released", pwrdn_req, 0);
    pin_role_pd = 1'b0; pd_pin_n = 1'b0;
    @(negedge clk);
    chk("R9 reset role no pd", pwrdn_req, 0);
    pd_pin_n = 1'b1;
    clear_tmo();
  endtask

  task automatic t_restart();
    int od0;
    tmo_sel = 4'h3; revert_sel = 1'b0;
    write_freq(4'h9);
    od0 = od_cycles;
    ticks(2);
    write_freq(4'h9);
    ticks(2);
    chk("R4 restart no expiry", od_cycles - od0, 0);
    ticks(1);
    chk("R4 restart expiry", od_cycles - od0, PULSE);
    clear_tmo();
  endtask

  task automatic t_fine();
    fine_n = 7'h55; fine_r = 6'h2A; fine_en = 1'b1;
    @(negedge clk);
    chk("R10 N captured", fine_n_q, 7'h55);
    chk("R10 R captured", fine_r_q, 6'h2A);
    fine_n = 7'h11; fine_r = 6'h05;
    repeat (3) @(negedge clk);
    chk("R10 hold while high", fine_n_q, 7'h55);
    fine_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 hold while low", fine_r_q, 6'h2A);
    fine_en = 1'b1;
    @(negedge clk);
    chk("R10 second edge N", fine_n_q, 7'h11);
    chk("R10 second edge R", fine_r_q, 6'h05);
    fine_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_unprotected();
    t_escalate_strap();
    t_clear();
    t_escalate_prev();
    t_pin_role();
    t_restart();
    t_fine();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule